// File: doc/BRIEF.md
# Audio Codec Controller Register Front End

This block is the processor-facing register file of an audio codec controller. A soft processor reaches it over a simple 32-bit single-cycle bus with byte addresses. Through it the processor streams playback samples into a transmit queue and drains captured samples from a receive queue. It also runs single register accesses on the codec and watches a status word for queue fill levels, access completion, codec readiness and playback underrun.

On the codec side the block drives a request/acknowledge port. The port carries a 7-bit register address, 16-bit write data and a read strobe, and it returns 16-bit read data. The serial link that carries these transactions to the codec sits outside the block. The playback queue is drained by one-cycle sample pulls from the link side, and the capture queue is filled by one-cycle sample pushes.

Top module: `codec_reg_frontend`

## Requirements
- R1: After reset the status word reads 0x08: only capture-empty is set, and playback-full, playback-half, capture-full, access-finished, codec-ready and underrun are all clear. `cdc_req` is low.
- R2: The register map uses bus_addr[4:2] as the word index. The words are: 0x00 playback data (write-only, reads 0), 0x04 capture data, 0x08 status, 0x0C control (write-only, reads 0), 0x10 access address, 0x14 codec read data, 0x18 codec write data (read/write). The status bits are: bit0 playback full, bit1 playback half, bit2 capture full, bit3 capture empty, bit4 access finished, bit5 codec ready, bit6 playback underrun.
- R3: A write to 0x10 with bit 7 clear, made while no access is pending, starts a codec write. From the next cycle `cdc_req` is high, `cdc_rd` is 0, `cdc_addr` is bits [6:0] of the written value, and `cdc_wdata` is the write-data word as it was at the launch. These hold until `cdc_ack`.
- R4: A write to 0x10 with bit 7 set starts a codec read with `cdc_rd`=1. The `cdc_rdata` value sampled with `cdc_ack` appears at 0x14. Word 0x10 reads back the 8-bit value written.
- R5: Access-finished clears on launch and sets on the cycle after `cdc_ack`, when `cdc_req` drops. A write to 0x10 while an access is pending is ignored.
- R6: Codec-ready follows `cdc_ready` one cycle late. It is forced low from the launch of a write to codec register 0x00 until that access has been acknowledged.
- R7: The playback queue holds 16 samples of 16 bits in arrival order. Full means 16 entries and half means 8 or more. Writes made while it is full are dropped.
- R8: A one-cycle `pb_pull` loads the oldest playback sample into `pb_sample` on that edge. A pull while the queue is empty loads 0 and sets underrun.
- R9: Underrun stays set, even across a queue clear, until a playback write is accepted.
- R10: A control write clears the playback queue when bit0 is set and the capture queue when bit1 is set. 0x3 clears both.
- R11: `cap_push` stores `cap_sample` unless the capture queue holds 16. A bus read of 0x04 returns the oldest entry and removes it, and it returns 0 when the queue is empty.
- R12: Writes to status and to codec read data change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus cycle valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| cdc_req | output | 1 | Codec register access pending |
| cdc_rd | output | 1 | Access is a read |
| cdc_addr | output | 7 | Codec register address |
| cdc_wdata | output | 16 | Codec register write data |
| cdc_ack | input | 1 | Access complete |
| cdc_rdata | input | 16 | Codec register read data |
| cdc_ready | input | 1 | Codec reports ready |
| pb_pull | input | 1 | Take one playback sample |
| pb_sample | output | 16 | Last pulled playback sample |
| cap_push | input | 1 | Store one capture sample |
| cap_sample | input | 16 | Capture sample to store |

## Verification
The hardest case to reach from the ports is a second address write that lands while an access is still pending. The bench makes it happen by issuing two address writes back to back against a codec stub that only acknowledges after several cycles. It then shows that the codec saw exactly one access and that the read data and echoed address belong to the first write. The codec-ready hold-off during a reset write is also hard to see, because the ready input stays high throughout. It only shows up in a status read taken in the few cycles before the stub acknowledges. Queue boundaries are reached by sweeping writes and pushes past 16 entries and pulls past empty, with every expected flag worked out from the running count.

// File: rtl/codec_reg_frontend.sv
module codec_reg_frontend #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int CAW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [4:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          cdc_req,
  output logic          cdc_rd,
  output logic [CAW-1:0] cdc_addr,
  output logic [DW-1:0] cdc_wdata,
  input  logic          cdc_ack,
  input  logic [DW-1:0] cdc_rdata,
  input  logic          cdc_ready,
  input  logic          pb_pull,
  output logic [DW-1:0] pb_sample,
  input  logic          cap_push,
  input  logic [DW-1:0] cap_sample
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  wire       bwr  = bus_sel & bus_we;
  wire       brd  = bus_sel & ~bus_we;
  wire [2:0] widx = bus_addr[4:2];

  logic [DW-1:0] pb_mem [DEPTH];
  logic [PW-1:0] pb_wp, pb_rp;
  logic [CW-1:0] pb_cnt;
  logic [DW-1:0] cap_mem [DEPTH];
  logic [PW-1:0] cap_wp, cap_rp;
  logic [CW-1:0] cap_cnt;
  logic          underrun, busy, done, rst_pend, rdy;
  logic [CAW:0]  acc_addr;
  logic [DW-1:0] wdat_r, rdat_r;

  wire pb_push  = bwr && widx == 3'd0 && pb_cnt != FULL;
  wire pb_pop   = pb_pull && pb_cnt != '0;
  wire cap_wr   = cap_push && cap_cnt != FULL;
  wire cap_pop  = brd && widx == 3'd1 && cap_cnt != '0;
  wire clr_pb   = bwr && widx == 3'd3 && bus_wdata[0];
  wire clr_cap  = bwr && widx == 3'd3 && bus_wdata[1];
  wire launch   = bwr && widx == 3'd4 && !busy;
  wire launch_r = launch && !bus_wdata[CAW] && bus_wdata[CAW-1:0] == '0;

  always_ff @(posedge clk) begin
    if (pb_push) pb_mem[pb_wp] <= bus_wdata[DW-1:0];
    if (cap_wr)  cap_mem[cap_wp] <= cap_sample;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pb_wp <= '0; pb_rp <= '0; pb_cnt <= '0;
    end else if (clr_pb) begin
      pb_wp <= '0; pb_rp <= '0; pb_cnt <= '0;
    end else begin
      if (pb_push) pb_wp <= pb_wp + 1'b1;
      if (pb_pop)  pb_rp <= pb_rp + 1'b1;
      pb_cnt <= pb_cnt + CW'(pb_push) - CW'(pb_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_wp <= '0; cap_rp <= '0; cap_cnt <= '0;
    end else if (clr_cap) begin
      cap_wp <= '0; cap_rp <= '0; cap_cnt <= '0;
    end else begin
      if (cap_wr)  cap_wp <= cap_wp + 1'b1;
      if (cap_pop) cap_rp <= cap_rp + 1'b1;
      cap_cnt <= cap_cnt + CW'(cap_wr) - CW'(cap_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pb_sample <= '0;
      underrun  <= 1'b0;
    end else begin
      if (pb_pull) pb_sample <= pb_pop ? pb_mem[pb_rp] : '0;
      if (pb_pull && pb_cnt == '0) underrun <= 1'b1;
      else if (pb_push)            underrun <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; rst_pend <= 1'b0; rdy <= 1'b0;
      acc_addr <= '0; wdat_r <= '0; rdat_r <= '0; cdc_wdata <= '0;
    end else begin
      if (bwr && widx == 3'd6) wdat_r <= bus_wdata[DW-1:0];
      if (launch) begin
        busy      <= 1'b1;
        done      <= 1'b0;
        acc_addr  <= bus_wdata[CAW:0];
        cdc_wdata <= wdat_r;
        rst_pend  <= launch_r;
      end else if (busy && cdc_ack) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        rst_pend <= 1'b0;
        if (acc_addr[CAW]) rdat_r <= cdc_rdata;
      end
      rdy <= cdc_ready && !rst_pend && !launch_r;
    end
  end

  assign cdc_req  = busy;
  assign cdc_rd   = acc_addr[CAW];
  assign cdc_addr = acc_addr[CAW-1:0];

  wire [6:0] status = {underrun, rdy, done, cap_cnt == '0, cap_cnt == FULL,
                       pb_cnt >= HALF, pb_cnt == FULL};

  always_comb begin
    case (widx)
      3'd1:    bus_rdata = (cap_cnt != '0) ? 32'(cap_mem[cap_rp]) : '0;
      3'd2:    bus_rdata = 32'(status);
      3'd4:    bus_rdata = 32'(acc_addr);
      3'd5:    bus_rdata = 32'(rdat_r);
      3'd6:    bus_rdata = 32'(wdat_r);
      default: bus_rdata = '0;
    endcase
  end

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cdc_req && !cdc_ack |=> cdc_req && $stable(cdc_addr) && $stable(cdc_wdata) && $stable(cdc_rd));
  assert_done_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cdc_req && cdc_ack |=> !cdc_req && status[4]);
  assert_ready_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    launch_r |=> !status[5]);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pb_cnt <= FULL && cap_cnt <= FULL);
  assert_underrun_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pb_pull && pb_cnt == '0 |=> underrun && pb_sample == '0);
  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !pb_push |=> underrun);
endmodule

// File: tb/test_codec_reg_frontend.sv
module test_codec_reg_frontend;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic cdc_req, cdc_rd, cdc_ack, cdc_ready = 0;
  logic [6:0] cdc_addr;
  logic [15:0] cdc_wdata, cdc_rdata;
  logic pb_pull = 0, cap_push = 0;
  logic [15:0] pb_sample, cap_sample = 0;
  int nchk = 0, nfail = 0, nacc = 0, scnt = 0;
  logic [6:0] last_wa;
  logic [15:0] last_wd;

  always #10 clk = ~clk;

  codec_reg_frontend i_codec_reg_frontend (.*);

  function automatic logic [15:0] fdat(input logic [6:0] a);
    return 16'h5A00 ^ (16'(a) * 16'd517);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cdc_ack <= 0; scnt <= 0; cdc_rdata <= 0;
    end else if (cdc_req && !cdc_ack) begin
      if (scnt == 2) begin
        cdc_ack <= 1; scnt <= 0; nacc <= nacc + 1;
        cdc_rdata <= fdat(cdc_addr);
        if (!cdc_rd) begin last_wa <= cdc_addr; last_wd <= cdc_wdata; end
      end else scnt <= scnt + 1;
    end else cdc_ack <= 0;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bwrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic bread(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic pull();
    @(negedge clk); pb_pull = 1;
    @(negedge clk); pb_pull = 0;
  endtask

  task automatic push(input logic [15:0] v);
    @(negedge clk); cap_push = 1; cap_sample = v;
    @(negedge clk); cap_push = 0;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int k = 0; k < 20; k++) begin
      bread(5'h08, s);
      if (s[4]) return;
    end
    check("R5 finished timeout", 0, 1);
  endtask

  initial begin
    #4_000_000;
    nfail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    bread(5'h08, v); check("R1 reset status", v, 32'h08);
    check("R1 reset req", cdc_req, 0);
    bread(5'h00, v); check("R2 playback reads 0", v, 0);
    bread(5'h0C, v); check("R2 control reads 0", v, 0);
    bwrite(5'h18, 32'h0000_BEEF);
    bread(5'h18, v); check("R2 wdata readback", v, 32'hBEEF);

    cdc_ready = 1;
    bread(5'h08, v); check("R6 ready follows input", v[5], 1);

    // R3 codec writes
    for (int a = 1; a < 128; a += 21) begin
      bwrite(5'h18, 32'(16'h1234 + a));
      bwrite(5'h10, 32'(a));
      check("R3 req high", cdc_req, 1);
      check("R3 rd low", cdc_rd, 0);
      check("R3 addr", cdc_addr, 32'(a));
      wait_done();
      check("R3 stub addr", last_wa, 32'(a));
      check("R3 stub data", last_wd, 32'(16'h1234 + a));
    end

    // R4 codec reads over all addresses
    for (int a = 0; a < 128; a++) begin
      bwrite(5'h10, 32'(a | 8'h80));
      check("R4 rd strobe", cdc_rd, 1);
      wait_done();
      bread(5'h14, v); check("R4 read data", v, 32'(fdat(7'(a))));
      bread(5'h10, v); check("R4 addr echo", v, 32'(a | 8'h80));
    end

    // R5 finished clears on launch, second launch ignored
    n0 = nacc;
    bwrite(5'h10, 32'h85);
    bread(5'h08, v); check("R5 finished cleared", v[4], 0);
    bwrite(5'h10, 32'h03);
    wait_done();
    repeat (6) @(negedge clk);
    check("R5 one access", nacc - n0, 1);
    bread(5'h14, v); check("R5 first read kept", v, 32'(fdat(7'h05)));
    bread(5'h10, v); check("R5 addr kept", v, 32'h85);

    // R6 reset write holds ready low
    bwrite(5'h10, 32'h00);
    bread(5'h08, v); check("R6 ready low during reset write", v[5], 0);
    wait_done();
    @(negedge clk);
    bread(5'h08, v); check("R6 ready back", v[5], 1);
    cdc_ready = 0; @(negedge clk);
    bread(5'h08, v); check("R6 ready drops", v[5], 0);
    cdc_ready = 1;

    // R7 playback fill sweep
    bwrite(5'h0C, 3);
    for (int i = 0; i < 20; i++) begin
      int c;
      bwrite(5'h00, 32'(i * 16'h0101 + 1));
      c = (i + 1 > 16) ? 16 : i + 1;
      bread(5'h08, v);
      check("R7 full flag", v[0], c == 16);
      check("R7 half flag", v[1], c >= 8);
    end
    // R8 drain in order, then underrun
    for (int k = 0; k < 16; k++) begin
      pull(); check("R8 order", pb_sample, 32'(k * 16'h0101 + 1));
    end
    bread(5'h08, v); check("R8 no underrun yet", v[6], 0);
    pull(); check("R8 empty gives 0", pb_sample, 0);
    bread(5'h08, v); check("R8 underrun set", v[6], 1);
    bwrite(5'h0C, 1);
    bread(5'h08, v); check("R9 survives clear", v[6], 1);
    bwrite(5'h00, 32'h77);
    bread(5'h08, v); check("R9 cleared by write", v[6], 0);

    // R11 capture sweep
    bwrite(5'h0C, 2);
    for (int i = 0; i < 18; i++) begin
      int c;
      push(16'(i * 3 + 100));
      c = (i + 1 > 16) ? 16 : i + 1;
      bread(5'h08, v);
      check("R11 cap full", v[2], c == 16);
      check("R11 cap empty", v[3], 0);
    end
    for (int k = 0; k < 16; k++) begin
      bread(5'h04, v); check("R11 cap order", v, 32'(k * 3 + 100));
    end
    bread(5'h04, v); check("R11 empty read 0", v, 0);
    bread(5'h08, v); check("R11 empty flag", v[3], 1);

    // R10 selective clears
    bwrite(5'h0C, 3);
    bwrite(5'h00, 32'h0A0A);
    push(16'h00C1);
    bwrite(5'h0C, 2);
    bread(5'h08, v); check("R10 cap cleared", v[3], 1);
    pull(); check("R10 pb kept", pb_sample, 32'h0A0A);
    bwrite(5'h00, 32'h0B0B);
    push(16'h00C2);
    bwrite(5'h0C, 1);
    bread(5'h08, v); check("R10 cap kept", v[3], 0);
    pull(); check("R10 pb cleared", pb_sample, 0);
    bwrite(5'h0C, 3);

    // R12 read-only writes ignored
    bwrite(5'h08, 32'hFFFF_FFFF);
    bwrite(5'h14, 32'hFFFF_FFFF);
    bread(5'h08, v); check("R12 status unchanged", v & 32'h2F, 32'h28);
    bread(5'h14, v); check("R12 rdata unchanged", v, 32'(fdat(7'h05)));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule